// File: doc/BRIEF.md
# Power Mode and Reference Controller

This block sits behind the serial command receiver of a voltage-output converter. It turns decoded command words into one of three power states. In the run state the output buffer drives. In the standby state the output is high impedance but the internal reference stays powered. In the off state the output and the reference are both off. The block also holds the 2-bit selection of the internal reference level. It drives three registered controls: an output-buffer enable (low means high impedance), a reference enable, and an output-valid flag.

Output-valid drops on the same clock edge that takes the block into standby or off. After a wake-up it rises only once a delay, counted in system clock cycles, has elapsed. The delay depends on the state being left. Leaving standby costs only the converter wake-up time. Leaving the off state costs the converter wake-up time plus the reference wake-up time, because the reference has to start again. Standby cannot be entered from the off state. To get from off to standby, the host sends a wake command and then a standby command.

Each command is a 4-bit code with a one-cycle valid strobe, sampled on the rising clock edge. The two most significant payload bits of the command word come with it. The state outputs change on the edge that accepts the command.

Top module: `pmr_top`

## Requirements
- R1: Synchronous reset puts the block in the run state (mode 2'b00), with reference selection 2'b00, output drive on, reference on and output-valid high.
- R2: An accepted code 4'b1100 in the run state moves to standby (mode 2'b01). From that edge the output drive is off, the reference stays on and output-valid is low.
- R3: Code 4'b1100 accepted in the off state is ignored: the mode stays 2'b10 and the reference selection is not changed.
- R4: An accepted code 4'b1110 moves to the off state (mode 2'b10) from any state. From that edge the output drive, the reference enable and output-valid are all low.
- R5: Codes 4'b1101, 4'b1000, 4'b1001 and 4'b1111 accepted in standby or off return the block to the run state (mode 2'b00). From that edge the output drive and the reference enable are high.
- R6: Codes 4'b1100, 4'b1101 and 4'b1110, when accepted, load the reference selection from the 2-bit payload field (except in the case of R3). No other code changes the selection.
- R7: After a wake command leaves standby, output-valid is low for DAC_WAKE cycles and rises on the DAC_WAKE-th rising edge after the accepting edge.
- R8: After a wake command leaves the off state, output-valid rises on the (DAC_WAKE+REF_WAKE)-th rising edge after the accepting edge.
- R9: Codes 4'b0000, 4'b0001 and the reserved codes, any code while the valid strobe is low, and wake codes received in the run state leave the mode and output-valid unchanged.
- R10: A standby or off command accepted on the same edge on which the wake-up count would complete wins: output-valid stays low.
- R11: An off command, then a wake command, then a standby command on consecutive cycles ends in standby with the selection from the last command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is present |
| cmd_op | input | 4 | Command code |
| cmd_sel | input | SEL_W | Two most significant payload bits, the reference selection field |
| mode | output | 2 | Power state: 00 run, 01 standby, 10 off |
| ref_sel | output | SEL_W | Current internal reference selection |
| drive_en | output | 1 | Output buffer enable; low means high impedance |
| ref_en | output | 1 | Internal reference enable |
| out_valid | output | 1 | Output is settled and valid |

## Verification
The wake-up counter finishing and a new sleep command can land on the same clock edge. The bench provokes this by issuing a wake from standby and then placing an off command exactly DAC_WAKE cycles later. The check requires output-valid to stay low on that edge and on the next one, with the off state in place. Payload selection and a state change also coincide on every standby, off and run command. These are judged together: each expected record compares mode, selection and all three enables in the cycle after acceptance.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_STBY = 2'b01,
    PM_OFF  = 2'b10
  } pm_mode_e;

  localparam logic [OP_W-1:0] OP_LOAD_UPD      = 4'b1000;
  localparam logic [OP_W-1:0] OP_WRITE_UPD     = 4'b1001;
  localparam logic [OP_W-1:0] OP_GO_STBY       = 4'b1100;
  localparam logic [OP_W-1:0] OP_GO_RUN        = 4'b1101;
  localparam logic [OP_W-1:0] OP_GO_OFF        = 4'b1110;
  localparam logic [OP_W-1:0] OP_WRITE_UPD_ALT = 4'b1111;

  typedef struct packed {
    logic wake;
    logic stby;
    logic off;
    logic sel_ld;
  } pm_req_t;

endpackage

// File: rtl/pmr_cmd_decode.sv
module pmr_cmd_decode
  import pmr_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output pm_req_t         req_o
);

  always_comb begin
    req_o = '0;
    if (valid_i) begin
      case (op_i)
        OP_GO_STBY: begin
          req_o.stby   = 1'b1;
          req_o.sel_ld = 1'b1;
        end
        OP_GO_OFF: begin
          req_o.off    = 1'b1;
          req_o.sel_ld = 1'b1;
        end
        OP_GO_RUN: begin
          req_o.wake   = 1'b1;
          req_o.sel_ld = 1'b1;
        end
        OP_LOAD_UPD, OP_WRITE_UPD, OP_WRITE_UPD_ALT: begin
          req_o.wake = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pmr_mode_fsm.sv
module pmr_mode_fsm
  import pmr_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  pm_req_t          req_i,
  input  logic [SEL_W-1:0] sel_i,
  output pm_mode_e         mode_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             drive_en_o,
  output logic             ref_en_o,
  output logic             start_o,
  output logic             start_long_o,
  output logic             sleep_o
);

  pm_mode_e         mode_q, mode_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             drive_q, ref_q;
  logic             stby_blocked;

  assign stby_blocked = req_i.stby && (mode_q == PM_OFF);

  always_comb begin
    mode_d       = mode_q;
    sel_d        = sel_q;
    start_o      = 1'b0;
    start_long_o = 1'b0;
    sleep_o      = 1'b0;
    if (req_i.off) begin
      mode_d  = PM_OFF;
      sleep_o = 1'b1;
    end else if (req_i.stby) begin
      if (!stby_blocked) begin
        mode_d  = PM_STBY;
        sleep_o = 1'b1;
      end
    end else if (req_i.wake && (mode_q != PM_RUN)) begin
      mode_d       = PM_RUN;
      start_o      = 1'b1;
      start_long_o = (mode_q == PM_OFF);
    end
    if (req_i.sel_ld && !stby_blocked) begin
      sel_d = sel_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PM_RUN;
      sel_q   <= '0;
      drive_q <= 1'b1;
      ref_q   <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      sel_q   <= sel_d;
      drive_q <= (mode_d == PM_RUN);
      ref_q   <= (mode_d != PM_OFF);
    end
  end

  assign mode_o     = mode_q;
  assign sel_o      = sel_q;
  assign drive_en_o = drive_q;
  assign ref_en_o   = ref_q;

  AST_NO_OFF_TO_STBY: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_OFF) |=> (mode_q != PM_STBY)); // R3

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!req_i.sel_ld) |=> $stable(sel_q)); // R6

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_i.wake, req_i.stby, req_i.off})); // R9

endmodule

// File: rtl/pmr_wake_timer.sv
module pmr_wake_timer #(
  parameter int DAC_WAKE = 5,
  parameter int REF_WAKE = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic start_long_i,
  input  logic sleep_i,
  output logic valid_o
);

  localparam int LONG_DLY = DAC_WAKE + REF_WAKE;
  localparam int CNT_W    = (LONG_DLY < 1) ? 1 : $clog2(LONG_DLY + 1);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_DLY);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(DAC_WAKE);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_v;
  logic             valid_q;

  assign load_v = start_long_i ? LONG_C : SHORT_C;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (sleep_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= load_v;
      valid_q <= (load_v == '0);
    end else if (!valid_q && (cnt_q != '0)) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_q   <= '0;
        valid_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign valid_o = valid_q;

  AST_RISE_NOT_ON_SLEEP: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> !$past(sleep_i)); // R10

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LONG_C); // R8

endmodule

// File: rtl/pmr_top.sv
module pmr_top
  import pmr_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int DAC_WAKE = 5,
  parameter int REF_WAKE = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_sel,
  output logic [1:0]       mode,
  output logic [SEL_W-1:0] ref_sel,
  output logic             drive_en,
  output logic             ref_en,
  output logic             out_valid
);

  pm_req_t  req;
  pm_mode_e mode_q;
  logic     start, start_long, sleep;

  pmr_cmd_decode u_dec (
    .valid_i (cmd_valid),
    .op_i    (cmd_op),
    .req_o   (req)
  );

  pmr_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req),
    .sel_i        (cmd_sel),
    .mode_o       (mode_q),
    .sel_o        (ref_sel),
    .drive_en_o   (drive_en),
    .ref_en_o     (ref_en),
    .start_o      (start),
    .start_long_o (start_long),
    .sleep_o      (sleep)
  );

  pmr_wake_timer #(.DAC_WAKE(DAC_WAKE), .REF_WAKE(REF_WAKE)) u_tmr (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .start_long_i (start_long),
    .sleep_i      (sleep),
    .valid_o      (out_valid)
  );

  assign mode = mode_q;

  AST_OFF_ALL_DARK: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_OFF) |-> (!drive_en && !ref_en && !out_valid)); // R4

  AST_STBY_KEEPS_REF: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_STBY) |-> (ref_en && !drive_en && !out_valid)); // R2

  AST_VALID_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (drive_en && mode_q == PM_RUN)); // R7

endmodule

// File: tb/test_pmr_top.sv
`timescale 1ns/1ps
module test_pmr_top;

  localparam int DW = 5;
  localparam int RW = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'h0;
  logic [1:0] cmd_sel = 2'b00;
  logic [1:0] mode;
  logic [1:0] ref_sel;
  logic       drive_en, ref_en, out_valid;

  always #4 clk = ~clk;

  pmr_top #(.SEL_W(2), .DAC_WAKE(DW), .REF_WAKE(RW)) i_pmr_top (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_sel),
    .mode      (mode),
    .ref_sel   (ref_sel),
    .drive_en  (drive_en),
    .ref_en    (ref_en),
    .out_valid (out_valid)
  );

  typedef struct {
    int         cyc;
    logic [1:0] mode;
    logic [1:0] sel;
    logic       de;
    logic       re;
    logic       ov;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // Monitor: samples 2 ns after each rising edge, compares due records.
  always @(posedge clk) begin
    #2;
    cyc++;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        checks++;
        if (mode !== sb[i].mode || ref_sel !== sb[i].sel || drive_en !== sb[i].de ||
            ref_en !== sb[i].re || out_valid !== sb[i].ov) begin
          fails++;
          $display("FAIL %s cycle %0d: got mode=%b sel=%b de=%b re=%b ov=%b, expected mode=%b sel=%b de=%b re=%b ov=%b",
                   sb[i].tag, cyc, mode, ref_sel, drive_en, ref_en, out_valid,
                   sb[i].mode, sb[i].sel, sb[i].de, sb[i].re, sb[i].ov);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(input int c, input logic [1:0] m, input logic [1:0] s,
                           input logic de, input logic re, input logic ov, input string tag);
    exp_t e;
    e.cyc = c; e.mode = m; e.sel = s; e.de = de; e.re = re; e.ov = ov; e.tag = tag;
    sb.push_back(e);
  endtask

  // Driver: presents a command for one edge; returns the stamp of that edge.
  task automatic cmd(input logic [3:0] op, input logic [1:0] s, output int st);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_sel   = s;
    st        = cyc + 1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got no finish, expected finish");
    summary();
    $finish;
  end

  initial begin
    int st, s0;
    // R1: reset state
    repeat (3) @(negedge clk);
    expect_at(cyc + 1, 2'b00, 2'b00, 1, 1, 1, "R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    expect_at(cyc + 1, 2'b00, 2'b00, 1, 1, 1, "R1 after reset");
    idle(2);

    // R2 R6: run -> standby, selection loaded
    cmd(4'b1100, 2'b10, st);
    expect_at(st, 2'b01, 2'b10, 0, 1, 0, "R2 R6 standby");
    idle(2);

    // R5 R7: wake from standby, short delay
    cmd(4'b1101, 2'b01, st);
    expect_at(st,          2'b00, 2'b01, 1, 1, 0, "R5 R6 wake from standby");
    expect_at(st + DW - 1, 2'b00, 2'b01, 1, 1, 0, "R7 not yet valid");
    expect_at(st + DW,     2'b00, 2'b01, 1, 1, 1, "R7 valid");
    idle(DW + 3);

    // R4 R6: run -> off
    cmd(4'b1110, 2'b11, st);
    expect_at(st, 2'b10, 2'b11, 0, 0, 0, "R4 R6 off");
    idle(2);

    // R3: standby request while off is ignored, selection kept
    cmd(4'b1100, 2'b00, st);
    expect_at(st,     2'b10, 2'b11, 0, 0, 0, "R3 standby blocked");
    expect_at(st + 1, 2'b10, 2'b11, 0, 0, 0, "R3 still off");
    idle(1);

    // R9: no-op, load-input and reserved codes
    cmd(4'b0001, 2'b00, st);
    expect_at(st, 2'b10, 2'b11, 0, 0, 0, "R9 load-input code");
    cmd(4'b0000, 2'b01, st);
    expect_at(st, 2'b10, 2'b11, 0, 0, 0, "R9 no-op code");
    cmd(4'b1010, 2'b00, st);
    expect_at(st, 2'b10, 2'b11, 0, 0, 0, "R9 reserved code");
    idle(1);

    // R5 R8: wake from off, long delay, selection untouched by 1000
    cmd(4'b1000, 2'b00, st);
    expect_at(st,               2'b00, 2'b11, 1, 1, 0, "R5 R6 wake from off");
    expect_at(st + DW + RW - 1, 2'b00, 2'b11, 1, 1, 0, "R8 not yet valid");
    expect_at(st + DW + RW,     2'b00, 2'b11, 1, 1, 1, "R8 valid");
    idle(DW + RW + 2);

    // R9: wake codes in run; R6: 1101 still loads selection
    cmd(4'b1111, 2'b10, st);
    expect_at(st, 2'b00, 2'b11, 1, 1, 1, "R9 wake in run");
    cmd(4'b1101, 2'b00, st);
    expect_at(st, 2'b00, 2'b00, 1, 1, 1, "R6 R9 run code in run");
    idle(2);

    // R9: off code on the bus with strobe low
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 4'b1110;
    cmd_sel   = 2'b10;
    expect_at(cyc + 1, 2'b00, 2'b00, 1, 1, 1, "R9 strobe low");
    expect_at(cyc + 2, 2'b00, 2'b00, 1, 1, 1, "R9 strobe low hold");
    idle(3);

    // R11: off, wake, standby back to back
    cmd(4'b1110, 2'b01, st);
    expect_at(st, 2'b10, 2'b01, 0, 0, 0, "R11 off");
    cmd(4'b1001, 2'b00, st);
    expect_at(st, 2'b00, 2'b01, 1, 1, 0, "R11 wake");
    cmd(4'b1100, 2'b10, st);
    expect_at(st, 2'b01, 2'b10, 0, 1, 0, "R11 standby");
    idle(2);

    // R10: sleep lands on the completion edge of the wake count
    cmd(4'b1101, 2'b11, s0);
    expect_at(s0,          2'b00, 2'b11, 1, 1, 0, "R7 wake before collision");
    expect_at(s0 + DW - 1, 2'b00, 2'b11, 1, 1, 0, "R10 pre-collision");
    idle(DW - 1);
    cmd(4'b1110, 2'b00, st);
    expect_at(st,     2'b10, 2'b00, 0, 0, 0, "R10 sleep wins");
    expect_at(st + 1, 2'b10, 2'b00, 0, 0, 0, "R10 stays low");
    idle(4);

    done = 1'b1;
    idle(3);
    if (sb.size() != 0 || st != s0 + DW) begin
      fails++;
      $display("FAIL R10 scheduling: got %0d pending, stamp %0d, expected 0 pending, stamp %0d",
               sb.size(), st, s0 + DW);
    end
    summary();
    $finish;
  end

endmodule